// File: doc/BRIEF.md
# Read-Triggered RAM Banking Controller

This controller sits on the cartridge side of a processor bus that has no write strobe. Behind it are three 2K RAM banks and a 2K ROM. A control register picks which two of these four sources appear in the two 2K halves of a 4K cartridge window. Every bus cycle is a read. Writes are therefore built from reads in two steps. First, an access anywhere in a dedicated 256-byte page captures the low address byte as the value to store. Then, a later address cycle delivers that value either to RAM or to the control register.

Each address cycle is marked by a one-clock valid strobe. Only strobed cycles are counted. The RAM commit happens on the fifth strobed cycle after the capturing access, and only if writes are enabled and the target is RAM. The control register follows a looser rule: an access to its fixed offset loads it at any moment. The block drives a unified memory address, RAM and ROM selects, a RAM write enable, the write data and the configuration fields that leave the block. The RAM and ROM arrays themselves are outside it.

Top module: `rdtrig_bank`

## Requirements
- R1: After reset the control register is 0x00. The low half maps to bank 3 and the high half to ROM, with the ROM powered. Writes are disabled, `wrDelay` is 0 and no write is pending.
- R2: A cycle belongs to the window only when `busValid` is 1 and address bit 12 is 1. Address bits above 12 are ignored, so mirror addresses act identically. Outside the window both selects are 0.
- R3: A window access whose offset bits 11..8 are all zero loads offset bits 7..0 into the data latch. The latch drives `wrData` from the next cycle onward.
- R4: The pending value is committed with `ramWe`=1 during the fifth `busValid` cycle after the capturing access. Cycles with `busValid`=0 are not counted. The value goes to the address of that fifth cycle.
- R5: A commit needs control bit 1 (write enable) equal to 1 and a RAM target. If the fifth cycle falls in ROM, falls outside the window, or has writes disabled, the write is dropped and no longer pending.
- R6: A window access at offset 0xFF8 loads the control register from the latch. This happens regardless of the count or the write-enable bit. The same access cancels any pending write and never produces `ramWe`.
- R7: Control bits 7..5 appear on `wrDelay` and bit 0 on `romPwrDown`. While bit 0 is 1, `romSel` stays 0.
- R8: Control bits 4..2 (mode) choose the low/high sources as follows: 0→bank3/ROM, 1→bank1/ROM, 2→bank3/bank1, 3→bank1/bank3, 4→bank3/ROM, 5→bank2/ROM, 6→bank3/bank2, 7→bank2/bank3. `memAddr` is {source code, offset bits 10..0}, where the source code is bank1=00, bank2=01, bank3=10, ROM=11.
- R9: A new mapping applies from the address cycle immediately after the control register access.
- R10: A capturing access while a write is pending reloads the latch and restarts the count from one. The old value is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Address of the current bus cycle |
| busValid | input | 1 | High for one clock per address cycle |
| memAddr | output | 13 | Unified RAM/ROM address {source, offset} |
| ramSel | output | 1 | The current cycle addresses a RAM bank |
| romSel | output | 1 | The current cycle addresses the powered ROM |
| ramWe | output | 1 | Commit `wrData` to RAM at `memAddr` this cycle |
| wrData | output | 8 | Latched write value |
| wrDelay | output | 3 | Write pulse delay field of the control register |
| romPwrDown | output | 1 | ROM power-down field (1 = off) |

## Verification
The checker watches four things on every cycle:
- a RAM write enable never coincides with a ROM select, a control-register access or a cycle outside the window;
- a commit only occurs exactly five counted cycles after a capture;
- the latch holds still between captures;
- the configuration outputs change only after a control-register access.

Some behaviours can only be shown by the bench's scenarios:
- the full mode table;
- the mapping switching on the very next cycle;
- dropped writes that do not resurface later;
- count restarts on recapture;
- control loads in the middle of a count.

// File: rtl/rdtrig_bank_pkg.sv
package rdtrig_bank_pkg;

  // Source code placed in the top two bits of the unified memory address.
  typedef enum logic [1:0] {
    SRC_BANK1 = 2'b00,
    SRC_BANK2 = 2'b01,
    SRC_BANK3 = 2'b10,
    SRC_ROM   = 2'b11
  } srcSel_t;

  // Per-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic winHit;     // cycle lies in the cartridge window
    logic latchLoad;  // capture low address byte
    logic cfgLoad;    // load control register from latch
    logic commit;     // fifth counted cycle, inside the window
  } ctrlStrobe_t;

  // Control register field positions.
  localparam int CFG_W        = 8;
  localparam int CFG_PWR_BIT  = 0;
  localparam int CFG_WE_BIT   = 1;
  localparam int CFG_MODE_LSB = 2;
  localparam int CFG_MODE_W   = 3;
  localparam int CFG_DLY_LSB  = 5;
  localparam int CFG_DLY_W    = 3;

endpackage

// File: rtl/rdtrig_bank_map.sv
module rdtrig_bank_map
  import rdtrig_bank_pkg::*;
(
  input  logic [CFG_MODE_W-1:0] mode,
  output srcSel_t               lowSrc,
  output srcSel_t               highSrc
);

  always_comb begin
    unique case (mode)
      3'd0:    begin lowSrc = SRC_BANK3; highSrc = SRC_ROM;   end
      3'd1:    begin lowSrc = SRC_BANK1; highSrc = SRC_ROM;   end
      3'd2:    begin lowSrc = SRC_BANK3; highSrc = SRC_BANK1; end
      3'd3:    begin lowSrc = SRC_BANK1; highSrc = SRC_BANK3; end
      3'd4:    begin lowSrc = SRC_BANK3; highSrc = SRC_ROM;   end
      3'd5:    begin lowSrc = SRC_BANK2; highSrc = SRC_ROM;   end
      3'd6:    begin lowSrc = SRC_BANK3; highSrc = SRC_BANK2; end
      default: begin lowSrc = SRC_BANK2; highSrc = SRC_BANK3; end
    endcase
  end

endmodule

// File: rtl/rdtrig_bank_ctl.sv
module rdtrig_bank_ctl
  import rdtrig_bank_pkg::*;
#(
  parameter int              WIN_BIT    = 12,
  parameter int              PAGE_LSB   = 8,
  parameter int              COMMIT_GAP = 5,
  parameter logic [WIN_BIT-1:0] CFG_OFS = 12'hFF8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIN_BIT:0] busAddr,
  input  logic             busValid,
  output ctrlStrobe_t      strb
);

  localparam int CNT_W = $clog2(COMMIT_GAP + 1);

  logic             inWin;
  logic             isLatch;
  logic             isCfg;
  logic             atGap;
  logic             pending;
  logic [CNT_W-1:0] cnt;

  assign inWin   = busValid && busAddr[WIN_BIT];
  assign isLatch = inWin && (busAddr[WIN_BIT-1:PAGE_LSB] == '0);
  assign isCfg   = inWin && (busAddr[WIN_BIT-1:0] == CFG_OFS);
  assign atGap   = busValid && pending && (cnt == CNT_W'(COMMIT_GAP));

  always_comb begin
    strb           = '0;
    strb.winHit    = inWin;
    strb.latchLoad = isLatch;
    strb.cfgLoad   = isCfg;
    strb.commit    = atGap && inWin && !isLatch && !isCfg;
  end

  // cnt holds the index of the current cycle counted from the capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (isLatch) begin
      pending <= 1'b1;
      cnt     <= CNT_W'(1);
    end else if (isCfg) begin
      pending <= 1'b0;
    end else if (busValid && pending) begin
      if (atGap) pending <= 1'b0;
      else       cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rdtrig_bank_dp.sv
module rdtrig_bank_dp
  import rdtrig_bank_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFS_W-1:0]     busOfs,
  input  ctrlStrobe_t          strb,
  output logic [OFS_W:0]       memAddr,
  output logic                 ramSel,
  output logic                 romSel,
  output logic                 ramWe,
  output logic [DATA_W-1:0]    wrData,
  output logic [CFG_DLY_W-1:0] wrDelay,
  output logic                 romPwrDown
);

  localparam int HALF_W = OFS_W - 1;

  logic [DATA_W-1:0] latchQ;
  logic [CFG_W-1:0]  cfgQ;
  srcSel_t           lowSrc;
  srcSel_t           highSrc;
  srcSel_t           curSrc;
  logic              isRam;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               latchQ <= '0;
    else if (strb.latchLoad) latchQ <= busOfs[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= '0;
    else if (strb.cfgLoad) cfgQ <= latchQ;
  end

  rdtrig_bank_map u_map (
    .mode    (cfgQ[CFG_MODE_LSB +: CFG_MODE_W]),
    .lowSrc  (lowSrc),
    .highSrc (highSrc)
  );

  assign curSrc     = busOfs[HALF_W] ? highSrc : lowSrc;
  assign isRam      = (curSrc != SRC_ROM);
  assign memAddr    = {curSrc, busOfs[HALF_W-1:0]};
  assign ramSel     = strb.winHit && isRam;
  assign romSel     = strb.winHit && !isRam && !cfgQ[CFG_PWR_BIT];
  assign ramWe      = strb.commit && cfgQ[CFG_WE_BIT] && isRam;
  assign wrData     = latchQ;
  assign wrDelay    = cfgQ[CFG_DLY_LSB +: CFG_DLY_W];
  assign romPwrDown = cfgQ[CFG_PWR_BIT];

endmodule

// File: rtl/rdtrig_bank.sv
module rdtrig_bank
  import rdtrig_bank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_BIT    = 12,
  parameter int DATA_W     = 8,
  parameter int COMMIT_GAP = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busValid,
  output logic [WIN_BIT:0]     memAddr,
  output logic                 ramSel,
  output logic                 romSel,
  output logic                 ramWe,
  output logic [DATA_W-1:0]    wrData,
  output logic [CFG_DLY_W-1:0] wrDelay,
  output logic                 romPwrDown
);

  ctrlStrobe_t strb;
  logic        unusedHiBits;

  // Bits above the window bit only create mirrors.
  assign unusedHiBits = ^busAddr[ADDR_W-1:WIN_BIT+1];

  rdtrig_bank_ctl #(
    .WIN_BIT    (WIN_BIT),
    .COMMIT_GAP (COMMIT_GAP)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr[WIN_BIT:0]),
    .busValid (busValid),
    .strb     (strb)
  );

  rdtrig_bank_dp #(
    .OFS_W  (WIN_BIT),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busOfs     (busAddr[WIN_BIT-1:0]),
    .strb       (strb),
    .memAddr    (memAddr),
    .ramSel     (ramSel),
    .romSel     (romSel),
    .ramWe      (ramWe),
    .wrData     (wrData),
    .wrDelay    (wrDelay),
    .romPwrDown (romPwrDown)
  );

endmodule

// File: rtl/rdtrig_bank_chk.sv
module rdtrig_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busValid,
  input logic              ramSel,
  input logic              romSel,
  input logic              ramWe,
  input logic [DATA_W-1:0] wrData,
  input logic [2:0]        wrDelay,
  input logic              romPwrDown
);

  logic       capHit;
  logic       cfgHit;
  logic [2:0] sinceCap;

  assign capHit = busValid && busAddr[12] && (busAddr[11:8] == 4'h0);
  assign cfgHit = busValid && busAddr[12] && (busAddr[11:0] == 12'hFF8);

  // Independent count of valid cycles since the last capture, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            sinceCap <= 3'd7;
    else if (capHit)                      sinceCap <= 3'd1;
    else if (busValid && sinceCap != 3'd7) sinceCap <= sinceCap + 3'd1;
  end

  // R2 R5
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (busValid && busAddr[12] && ramSel && !romSel));

  // R2
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && romSel));

  // R4
  commit_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (sinceCap == 3'd5));

  // R6
  cfg_never_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgHit |-> !ramWe);

  // R7
  pwr_down_rom_chk: assert property (@(posedge clk) disable iff (!rstN)
    romPwrDown |-> !romSel);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capHit |=> $stable(wrData));

  // R6 R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgHit |=> $stable({wrDelay, romPwrDown}));

endmodule

bind rdtrig_bank rdtrig_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busValid   (busValid),
  .ramSel     (ramSel),
  .romSel     (romSel),
  .ramWe      (ramWe),
  .wrData     (wrData),
  .wrDelay    (wrDelay),
  .romPwrDown (romPwrDown)
);

// File: tb/rdtrig_bank_bench.sv
module rdtrig_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busValid = 1'b0;
  logic [12:0] memAddr;
  logic        ramSel, romSel, ramWe, romPwrDown;
  logic [7:0]  wrData;
  logic [2:0]  wrDelay;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // sampled outputs
  logic [12:0] sMem;
  logic        sRam, sRom, sWe, sPwr;
  logic [7:0]  sData;
  logic [2:0]  sDly;

  // expected {lowSrc, highSrc} per mode: bank1=00 bank2=01 bank3=10 ROM=11
  localparam logic [3:0] MODE_EXP [8] = '{
    4'b1011, 4'b0011, 4'b1000, 4'b0010,
    4'b1011, 4'b0111, 4'b1001, 4'b0110
  };

  always #5 clk = ~clk;

  rdtrig_bank u_rdtrig_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busValid(busValid),
    .memAddr(memAddr), .ramSel(ramSel), .romSel(romSel), .ramWe(ramWe),
    .wrData(wrData), .wrDelay(wrDelay), .romPwrDown(romPwrDown)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle (called right after a falling edge), sample before the rise.
  task automatic step(input logic [15:0] a, input logic v);
    busAddr = a;
    busValid = v;
    #4;
    sMem = memAddr; sRam = ramSel; sRom = romSel; sWe = ramWe;
    sData = wrData; sDly = wrDelay; sPwr = romPwrDown;
    @(negedge clk);
  endtask

  task automatic loadCfg(input logic [7:0] val);
    step(16'h1000 | 16'(val), 1'b1);
    step(16'h1FF8, 1'b1);
  endtask

  task automatic idle4(output bit sawWe);
    sawWe = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(16'h0080, 1'b1);
      if (sWe) sawWe = 1'b1;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit sawWe;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(16'h1234, 1'b1);
    chk("R1", "low half bank3 ramSel", {3'b0, sRam, sMem}, {3'b0, 1'b1, 13'h1234});
    chk("R1", "ramWe idle", 16'(sWe), 16'h0);
    step(16'h1ABC, 1'b1);
    chk("R1", "high half ROM", {2'b0, sRom, sRam, sMem}, {2'b0, 1'b1, 1'b0, 13'h1ABC});
    chk("R1", "cfg fields", {12'h0, sDly, sPwr}, 16'h0);

    // R8 R9 mode table walk
    for (int m = 0; m < 8; m++) begin
      loadCfg(8'(m << 2));
      step(16'h1234, 1'b1);
      chk("R9", "low src right after cfg",
          {3'b0, sRom, sMem}, {3'b0, (MODE_EXP[m][3:2] == 2'b11), MODE_EXP[m][3:2], 11'h234});
      step(16'h1ABC, 1'b1);
      chk("R8", "high src",
          {3'b0, sRom, sMem}, {3'b0, (MODE_EXP[m][1:0] == 2'b11), MODE_EXP[m][1:0], 11'h2BC});
    end

    // R3 R4 basic write, mode 2 (bank3/bank1) with writes on
    loadCfg(8'h0A);
    step(16'h105A, 1'b1);
    step(16'h0080, 1'b1);
    chk("R3", "latched data", 16'(sData), 16'h5A);
    sawWe = sWe;
    for (int i = 0; i < 3; i++) begin
      step(16'h0080, 1'b1);
      if (sWe) sawWe = 1'b1;
    end
    chk("R4", "no write before fifth", 16'(sawWe), 16'h0);
    step(16'h1823, 1'b1);
    chk("R4", "commit fifth cycle", {2'b0, sWe, sMem}, {2'b0, 1'b1, 13'h0023});
    chk("R4", "commit data", 16'(sData), 16'h5A);

    // R4 idle cycles not counted
    step(16'h1077, 1'b1);
    step(16'h0080, 1'b1);
    for (int i = 0; i < 3; i++) step(16'h1823, 1'b0);
    for (int i = 0; i < 3; i++) step(16'h0080, 1'b1);
    step(16'h1830, 1'b1);
    chk("R4", "commit with idles", {2'b0, sWe, sMem}, {2'b0, 1'b1, 13'h0030});

    // R2 mirror addresses
    step(16'hF0C3, 1'b1);
    idle4(sawWe);
    step(16'hF823, 1'b1);
    chk("R2", "mirror commit", {2'b0, sWe, sMem}, {2'b0, 1'b1, 13'h0023});
    chk("R2", "mirror latch", 16'(sData), 16'hC3);
    step(16'hE123, 1'b1);
    chk("R2", "outside window selects", {14'h0, sRam, sRom}, 16'h0);

    // R5 writes disabled
    loadCfg(8'h08);
    step(16'h1011, 1'b1);
    idle4(sawWe);
    step(16'h1823, 1'b1);
    chk("R5", "we bit off", {14'h0, sRam, sWe}, 16'h2);

    // R5 target in ROM, then not pending
    loadCfg(8'h06);
    step(16'h1044, 1'b1);
    idle4(sawWe);
    step(16'h1900, 1'b1);
    chk("R5", "rom target dropped", {14'h0, sRom, sWe}, 16'h2);
    step(16'h1100, 1'b1);
    chk("R5", "dropped stays dropped", 16'(sWe), 16'h0);

    // R5 target outside window
    step(16'h1045, 1'b1);
    idle4(sawWe);
    step(16'h0900, 1'b1);
    chk("R5", "outside target dropped", 16'(sWe), 16'h0);
    step(16'h1100, 1'b1);
    chk("R5", "outside drop stays dropped", 16'(sWe), 16'h0);

    // R10 recapture restarts count
    step(16'h1022, 1'b1);
    step(16'h0080, 1'b1);
    step(16'h0080, 1'b1);
    step(16'h1033, 1'b1);
    step(16'h0080, 1'b1);
    step(16'h1100, 1'b1);
    chk("R10", "old count no write", 16'(sWe), 16'h0);
    step(16'h0080, 1'b1);
    step(16'h0080, 1'b1);
    step(16'h1140, 1'b1);
    chk("R10", "restarted commit", {2'b0, sWe, sMem}, {2'b0, 1'b1, 13'h0140});
    chk("R10", "new value", 16'(sData), 16'h33);

    // R6 control offset as the fifth cycle in RAM (mode 3)
    loadCfg(8'h0E);
    step(16'h10EE, 1'b1);
    idle4(sawWe);
    step(16'h1FF8, 1'b1);
    chk("R6", "cfg offset no ram write", {14'h0, sRam, sWe}, 16'h2);
    step(16'h1100, 1'b1);
    chk("R7", "delay field", 16'(sDly), 16'h7);
    chk("R6", "after cfg no write", 16'(sWe), 16'h0);

    // R6 cfg load mid-count cancels pending, mapping switches
    step(16'h1016, 1'b1);
    step(16'h0080, 1'b1);
    step(16'h1FF8, 1'b1);
    step(16'h1100, 1'b1);
    chk("R6", "mid-count cfg bank2", {3'b0, sRam, sMem}, {3'b0, 1'b1, 13'h0900});
    step(16'h1100, 1'b1);
    step(16'h1100, 1'b1);
    chk("R6", "pending cancelled", 16'(sWe), 16'h0);

    // R7 ROM power-down
    loadCfg(8'h05);
    step(16'h1900, 1'b1);
    chk("R7", "rom off", {13'h0, sPwr, sRom, sRam}, 16'h4);

    // R6 cfg loads while writes disabled
    loadCfg(8'h0C);
    step(16'h1900, 1'b1);
    chk("R6", "cfg with we off", {2'b0, sPwr, sMem}, {2'b0, 1'b0, 13'h1100});

    // R1 reset again from a busy state
    loadCfg(8'hEA);
    step(16'h1066, 1'b1);
    rstN = 1'b0;
    step(16'h0080, 1'b0);
    rstN = 1'b1;
    step(16'h1ABC, 1'b1);
    chk("R1", "reset restores map", {2'b0, sRom, sMem}, {2'b0, 1'b1, 13'h1ABC});
    chk("R1", "reset clears fields", {4'h0, sData, sDly, sPwr}, 16'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule